// File: doc/BRIEF.md
# Multi-Channel Timer Register Front End

This block sits between a simple request/acknowledge register bus and two or three down-counting timer channels. It decodes a byte-addressed register window. One shared start register turns each channel on or off, one bit per channel. A one-bit output-control register can be configured in or out. All other accesses are forwarded into the channel that owns the address. Each channel drives its own interrupt line.

Each channel window sits at a fixed and irregular base. Window A starts at byte 0x08 and window B at 0x14. The optional window C starts at 0x20 and holds one extra word, a capture register. The base is subtracted from the address and the result is divided by four to form the channel word address. Every access is handled by a two-state bus machine. In ST_IDLE, a request is accepted: a write lands at that clock edge, and a read samples its data. The machine then moves to ST_RESP. ST_RESP drives the acknowledge, the read data and any error for exactly one cycle, then always returns to ST_IDLE. Any request seen in ST_RESP is ignored.

Top module: `tmr_front`

## Requirements
- R1: After reset, ack, err, out_ctl and every irq bit are 0, the start register reads 0, the output-control register reads 0, every channel reload and count word reads 0xFFFFFFFF, every control word reads 0, and the capture word reads the CAPT_INIT parameter.
- R2: A request accepted in ST_IDLE is acknowledged in the following cycle, for exactly one cycle; a request present while ack is high is ignored (no write, no response).
- R3: Byte 0x00 is the output-control register, present when HAS_OUTCTL is 1. Only wdata bit 0 is stored; reads return it in bit 0 with all other bits 0; it drives out_ctl.
- R4: Byte 0x04 is the start register; all 32 written bits are stored and a read returns the last written value.
- R5: Start bit n (n = 0, 1, 2) runs channel n while 1 and holds it while 0; a start write changes every channel from the clock edge after the write edge, all in the same cycle.
- R6: Channel windows begin at bytes 0x08, 0x14 and 0x20; word = (address - base) / 4, with word 0 = reload, 1 = count, 2 = control, 3 = capture (third channel only).
- R7: A running channel decrements its count once per clock; a running channel at count 0 loads the reload value instead and sets its underflow flag. A count write wins over counting, and no flag is set by that edge.
- R8: Control word bits 7:0 are stored; bit 8 reads the underflow flag. Writing bit 8 as 0 clears the flag and writing it as 1 leaves it unchanged. A same-edge underflow wins over a clear.
- R9: irq[n] is 1 exactly when channel n's underflow flag and control bit 5 are both 1; irq bits of absent channels are 0.
- R10: A misaligned address or an offset that decodes to no register returns 0, changes nothing, and raises err together with ack for one cycle.
- R11: With HAS_CH2 = 0, offsets 0x20 and above are undecoded, and a start write with bit 2 set raises err (the value is still stored). With HAS_OUTCTL = 0, offset 0x00 is undecoded.
- R12: The third channel's capture word (byte 0x2C) is readable and writable with all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled in ST_IDLE |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address within the window |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle response strobe |
| err | output | 1 | Bus error, valid with ack |
| rdata | output | DATA_W | Read data, valid with ack (0 for writes and errors) |
| out_ctl | output | 1 | Output-control bit |
| irq | output | 3 | Per-channel interrupt |

## Verification
Assertions check the following on every cycle: the acknowledge is a single-cycle pulse that follows a request; err never appears without ack, and an erroring response carries zero data; the start and output-control registers hold unless written; and a running channel at zero reloads and raises its flag. Only the bench's scenarios can show the rest. These are the decoded address map with its irregular bases, the value returned by each read, the simultaneous start of all channels, the interrupt gating against the control word, the flag-clear semantics, and the two-channel configuration with its error cases. These behaviours are compared against a behavioural model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_OUTCTL,
        TGT_START,
        TGT_CHAN
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [1:0] chan;
        logic [1:0] word;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_st_e;

    localparam logic [1:0] W_RELOAD = 2'd0;
    localparam logic [1:0] W_COUNT  = 2'd1;
    localparam logic [1:0] W_CTRL   = 2'd2;
    localparam logic [1:0] W_CAPT   = 2'd3;

    localparam int IRQ_EN_BIT = 5;
    localparam int FLAG_BIT   = 8;
    localparam int CTL_W      = 8;
    localparam int MAX_CH     = 3;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit HAS_CH2    = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] A_OUTCTL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] B_CH0    = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] B_CH1    = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] B_CH2    = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] E_CH2    = ADDR_W'(8'h30);

    logic [ADDR_W-1:0] base;

    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.chan = 2'd0;
        base     = B_CH0;
        if (addr[1:0] == 2'b00) begin
            if (addr == A_OUTCTL) begin
                if (HAS_OUTCTL) dec.tgt = TGT_OUTCTL;
            end else if (addr == A_START) begin
                dec.tgt = TGT_START;
            end else if (addr >= B_CH0 && addr < B_CH1) begin
                dec.tgt  = TGT_CHAN;
                dec.chan = 2'd0;
                base     = B_CH0;
            end else if (addr >= B_CH1 && addr < B_CH2) begin
                dec.tgt  = TGT_CHAN;
                dec.chan = 2'd1;
                base     = B_CH1;
            end else if (HAS_CH2 && addr >= B_CH2 && addr < E_CH2) begin
                dec.tgt  = TGT_CHAN;
                dec.chan = 2'd2;
                base     = B_CH2;
            end
        end
        dec.word = 2'((addr - base) >> 2);
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter bit                HAS_CAPT  = 1'b0,
    parameter logic [DATA_W-1:0] CAPT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [1:0]        word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] reload_q, count_q, capt_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              flag_q;
    logic              wr_count, wr_ctrl, underflow;

    assign wr_count  = wr_en && (word == W_COUNT);
    assign wr_ctrl   = wr_en && (word == W_CTRL);
    assign underflow = run && (count_q == '0) && !wr_count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '1;
            count_q  <= '1;
            ctl_q    <= '0;
            flag_q   <= 1'b0;
            capt_q   <= CAPT_INIT;
        end else begin
            if (wr_en && word == W_RELOAD) reload_q <= wdata;
            if (wr_count)                  count_q  <= wdata;
            else if (underflow)            count_q  <= reload_q;
            else if (run)                  count_q  <= count_q - 1'b1;
            if (underflow)                 flag_q   <= 1'b1;
            else if (wr_ctrl && !wdata[FLAG_BIT]) flag_q <= 1'b0;
            if (wr_ctrl)                   ctl_q    <= wdata[CTL_W-1:0];
            if (HAS_CAPT && wr_en && word == W_CAPT) capt_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (word)
            W_RELOAD: rdata = reload_q;
            W_COUNT:  rdata = count_q;
            W_CTRL: begin
                rdata[CTL_W-1:0] = ctl_q;
                rdata[FLAG_BIT]  = flag_q;
            end
            W_CAPT:   rdata = HAS_CAPT ? capt_q : '0;
        endcase
    end

    assign irq = flag_q && ctl_q[IRQ_EN_BIT];

    // R7: a running channel sitting at zero reloads on the next edge
    a_r7_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_q == '0 && !wr_count) |=> (count_q == $past(reload_q)));

    // R8: an underflow edge always leaves the flag set
    a_r8_flag_after_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_q == '0 && !wr_count) |=> flag_q);

endmodule

// File: rtl/tmr_front.sv
module tmr_front
    import tmr_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter bit                HAS_CH2    = 1'b1,
    parameter bit                HAS_OUTCTL = 1'b1,
    parameter logic [DATA_W-1:0] CAPT_INIT  = 32'hC0FF_EE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              out_ctl,
    output logic [MAX_CH-1:0] irq
);
    localparam int NCH = HAS_CH2 ? 3 : 2;

    bus_st_e           state, state_nx;
    dec_t              dec;
    logic              accept, wr, bad;
    logic [DATA_W-1:0] start_q, rd_mux, rdata_q;
    logic              outctl_q, err_q;
    logic [DATA_W-1:0] ch_rd [4];

    tmr_decode #(
        .ADDR_W(ADDR_W), .HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)
    ) u_dec (
        .addr(addr), .dec(dec)
    );

    assign accept = (state == ST_IDLE) && req;
    assign wr     = accept && we;
    assign bad    = (dec.tgt == TGT_NONE) ||
                    (dec.tgt == TGT_START && we && !HAS_CH2 && wdata[2]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    // shared registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            outctl_q <= 1'b0;
        end else begin
            if (wr && dec.tgt == TGT_START)  start_q  <= wdata;
            if (wr && dec.tgt == TGT_OUTCTL) outctl_q <= wdata[0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < 4; gi++) begin : g_ch
            if (gi < NCH) begin : g_on
                logic ch_irq;
                tmr_chan #(
                    .DATA_W(DATA_W), .HAS_CAPT(gi == 2), .CAPT_INIT(CAPT_INIT)
                ) u_chan (
                    .clk(clk), .rst_n(rst_n),
                    .run(start_q[gi]),
                    .wr_en(wr && dec.tgt == TGT_CHAN && dec.chan == 2'(gi)),
                    .word(dec.word), .wdata(wdata),
                    .rdata(ch_rd[gi]), .irq(ch_irq)
                );
                if (gi < MAX_CH) begin : g_irq
                    assign irq[gi] = ch_irq;
                end
            end else begin : g_off
                assign ch_rd[gi] = '0;
                if (gi < MAX_CH) begin : g_irq
                    assign irq[gi] = 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        unique case (dec.tgt)
            TGT_NONE:   rd_mux = '0;
            TGT_OUTCTL: rd_mux[0] = outctl_q;
            TGT_START:  rd_mux = start_q;
            TGT_CHAN:   rd_mux = ch_rd[dec.chan];
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            err_q <= accept && bad;
            if (accept) rdata_q <= (we || bad) ? '0 : rd_mux;
        end
    end

    assign ack     = (state == ST_RESP);
    assign err     = err_q;
    assign rdata   = rdata_q;
    assign out_ctl = outctl_q;

    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));
    a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);
    a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '0));
    a_r4_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && dec.tgt == TGT_START) |=> $stable(start_q));
    a_r3_outctl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && dec.tgt == TGT_OUTCTL) |=> $stable(out_ctl));

endmodule

// File: tb/tmr_front_tb.sv
module tmr_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CAPT_RST = 32'hC0FF_EE00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack, err, out_ctl;
    logic [31:0] rdata;
    logic [2:0]  irq;

    logic        req2 = 1'b0, we2 = 1'b0;
    logic [7:0]  addr2 = '0;
    logic [31:0] wdata2 = '0;
    logic        ack2, err2, oc2;
    logic [31:0] rdata2;
    logic [2:0]  irq2;

    int checks = 0, errors = 0;
    string tag = "R1";
    bit started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_front u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .err(err), .rdata(rdata), .out_ctl(out_ctl), .irq(irq));

    tmr_front #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .req(req2), .we(we2), .addr(addr2), .wdata(wdata2),
        .ack(ack2), .err(err2), .rdata(rdata2), .out_ctl(oc2), .irq(irq2));

    // behavioural reference model of the three-channel build
    logic [31:0] m_reload [3], m_count [3];
    logic [7:0]  m_ctl [3];
    bit          m_flag [3];
    logic [31:0] m_capt, m_start, e_rdata;
    bit          m_outctl, m_busy, e_ack, e_err;

    function automatic void mdec(input logic [7:0] a, input bit ch2, input bit oc,
                                 output int kind, output int ch, output int wd);
        kind = 0; ch = 0; wd = 0;
        if (a[1:0] != 0) kind = 0;
        else if (a == 8'h00) kind = oc ? 1 : 0;
        else if (a == 8'h04) kind = 2;
        else if (a >= 8'h08 && a < 8'h14) begin kind = 3; ch = 0; wd = (a - 8'h08) / 4; end
        else if (a >= 8'h14 && a < 8'h20) begin kind = 3; ch = 1; wd = (a - 8'h14) / 4; end
        else if (ch2 && a >= 8'h20 && a < 8'h30) begin kind = 3; ch = 2; wd = (a - 8'h20) / 4; end
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_reload[i] = '1; m_count[i] = '1; m_ctl[i] = '0; m_flag[i] = 0;
            end
            m_capt = CAPT_RST; m_start = '0; m_outctl = 0;
            m_busy = 0; e_ack = 0; e_err = 0; e_rdata = '0;
        end else begin
            int kind, ch, wd;
            bit acc, bad;
            logic [31:0] rd, st_old;
            acc = !m_busy && req;
            st_old = m_start;
            mdec(addr, 1, 1, kind, ch, wd);
            bad = (kind == 0);
            rd = '0;
            if (kind == 1) rd = {31'd0, m_outctl};
            else if (kind == 2) rd = m_start;
            else if (kind == 3) begin
                case (wd)
                    0: rd = m_reload[ch];
                    1: rd = m_count[ch];
                    2: rd = {23'd0, m_flag[ch], m_ctl[ch]};
                    default: rd = (ch == 2) ? m_capt : '0;
                endcase
            end
            for (int i = 0; i < 3; i++) begin
                bit wrc, uf;
                wrc = acc && we && kind == 3 && ch == i;
                uf = st_old[i] && m_count[i] == 0 && !(wrc && wd == 1);
                if (wrc && wd == 1) m_count[i] = wdata;
                else if (uf) m_count[i] = m_reload[i];
                else if (st_old[i]) m_count[i] = m_count[i] - 1;
                if (uf) m_flag[i] = 1;
                else if (wrc && wd == 2 && !wdata[8]) m_flag[i] = 0;
                if (wrc && wd == 2) m_ctl[i] = wdata[7:0];
                if (wrc && wd == 0) m_reload[i] = wdata;
                if (wrc && wd == 3 && i == 2) m_capt = wdata;
            end
            if (acc && we && kind == 2) m_start = wdata;
            if (acc && we && kind == 1) m_outctl = wdata[0];
            e_ack = acc;
            e_err = acc && bad;
            if (acc) e_rdata = (we || bad) ? '0 : rd;
            m_busy = acc;
        end
    end

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (started) begin
            chk(ack === e_ack, "R2 ack", 32'(ack), 32'(e_ack));
            chk(err === e_err, "R10 err", 32'(err), 32'(e_err));
            if (e_ack) chk(rdata === e_rdata, {tag, " rdata"}, rdata, e_rdata);
            chk(irq === {m_flag[2] && m_ctl[2][5], m_flag[1] && m_ctl[1][5], m_flag[0] && m_ctl[0][5]},
                "R9 irq", 32'(irq),
                32'({m_flag[2] && m_ctl[2][5], m_flag[1] && m_ctl[1][5], m_flag[0] && m_ctl[0][5]}));
            chk(out_ctl === m_outctl, "R3 out_ctl", 32'(out_ctl), 32'(m_outctl));
        end
    end

    task automatic acc(input bit w, input logic [7:0] a, input logic [31:0] d, input string t);
        @(negedge clk);
        tag = t; req = 1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc2(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input bit x_err, input logic [31:0] x_rd);
        @(negedge clk);
        req2 = 1; we2 = w; addr2 = a; wdata2 = d;
        @(negedge clk);
        req2 = 0;
        chk(ack2 === 1'b1, "R11 ack", 32'(ack2), 32'd1);
        chk(err2 === x_err, "R11 err", 32'(err2), 32'(x_err));
        chk(rdata2 === x_rd, "R11 rdata", rdata2, x_rd);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset values
        acc(0, 8'h08, 0, "R1"); acc(0, 8'h0C, 0, "R1"); acc(0, 8'h10, 0, "R1");
        acc(0, 8'h04, 0, "R1"); acc(0, 8'h00, 0, "R1"); acc(0, 8'h2C, 0, "R1");
        chk(irq2 === 3'b000, "R1 irq2", 32'(irq2), 0);
        // R3 output control
        acc(1, 8'h00, 32'hFFFF_FFFE, "R3"); acc(0, 8'h00, 0, "R3");
        acc(1, 8'h00, 32'h0000_0003, "R3"); acc(0, 8'h00, 0, "R3");
        // R4 start register readback
        acc(1, 8'h04, 32'hA5A5_0000, "R4"); acc(0, 8'h04, 0, "R4");
        // R6 windows
        acc(1, 8'h08, 4, "R6"); acc(1, 8'h0C, 4, "R6"); acc(1, 8'h10, 32'h20, "R6");
        acc(1, 8'h14, 2, "R6"); acc(1, 8'h18, 2, "R6"); acc(1, 8'h1C, 32'h20, "R6");
        acc(1, 8'h20, 6, "R6"); acc(1, 8'h24, 6, "R6"); acc(1, 8'h28, 32'h00, "R6");
        acc(0, 8'h14, 0, "R6"); acc(0, 8'h20, 0, "R6");
        // R5 simultaneous start, R7 counting
        acc(1, 8'h04, 7, "R5");
        idle(13);
        acc(0, 8'h0C, 0, "R7"); acc(0, 8'h18, 0, "R7"); acc(0, 8'h24, 0, "R7");
        acc(0, 8'h10, 0, "R8"); acc(0, 8'h28, 0, "R8");
        // R8 flag clear semantics, R9 irq gating
        acc(1, 8'h10, 32'h120, "R8"); acc(0, 8'h10, 0, "R8");
        acc(1, 8'h10, 32'h020, "R8"); acc(0, 8'h10, 0, "R8");
        acc(1, 8'h28, 32'h020, "R9"); idle(9);
        // R5 stop channels 0 and 2
        acc(1, 8'h04, 2, "R5"); idle(4);
        acc(0, 8'h0C, 0, "R5"); acc(0, 8'h24, 0, "R5"); acc(0, 8'h18, 0, "R5");
        // R7 count write wins over counting
        acc(1, 8'h18, 32'h10, "R7"); acc(0, 8'h18, 0, "R7");
        // R2 request held through ack is ignored
        @(negedge clk);
        tag = "R2"; req = 1; we = 1; addr = 8'h04; wdata = 32'h3;
        @(negedge clk);
        wdata = 32'h55;
        @(negedge clk);
        req = 0;
        acc(0, 8'h04, 0, "R2");
        // R10 undecoded and misaligned
        acc(0, 8'h30, 0, "R10"); acc(1, 8'h31, 32'hFF, "R10");
        acc(1, 8'h40, 32'hFF, "R10"); acc(0, 8'h0A, 0, "R10");
        acc(1, 8'h2D, 32'h1, "R10"); acc(0, 8'h2C, 0, "R10");
        // R12 capture word
        acc(1, 8'h2C, 32'h1234_5678, "R12"); acc(0, 8'h2C, 0, "R12");
        acc(1, 8'h04, 0, "R5"); idle(3);
        // R11 two-channel build without output control
        acc2(1, 8'h04, 32'h7, 1'b1, 32'h0);
        acc2(0, 8'h04, 0, 1'b0, 32'h7);
        acc2(0, 8'h20, 0, 1'b1, 32'h0);
        acc2(1, 8'h00, 32'h1, 1'b1, 32'h0);
        chk(oc2 === 1'b0, "R11 out_ctl", 32'(oc2), 0);
        chk(irq2[2] === 1'b0, "R11 irq2", 32'(irq2[2]), 0);
        acc2(0, 8'h14, 0, 1'b0, 32'hFFFF_FFFF);
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule